// File: doc/BRIEF.md
# Access Control Region Matcher

This block holds a small set of region registers that carve fixed windows out of the address space ahead of the translation unit. Each register names a window by a base value and a don't-care mask on the top byte of the address. It also limits the window to a privilege level and to data or instruction accesses, and it carries a cache mode and a write-protect flag. For every access presented on the lookup port, the block reports whether a window claims the address. A claimed access bypasses translation entirely, so it can never produce a translation miss. The block then reports the winning window's index and attributes.

Software writes the registers through a single synchronous write port. The lookup side is purely combinational, so the result for an address is available in the same cycle it is presented. Writing zero to a register switches its window off.

Top module: `acr_match`

## Requirements
- R1: After reset every region register is zero, so no lookup reports a hit.
- R2: A region claims an address when, for each of the top eight address bits whose mask bit (register bits 23:16) is clear, the address bit equals the base bit (register bits 31:24). Base 0xC0 with mask 0x3F claims 0xC000_0000 to 0xFFFF_FFFF and not 0xBFFF_FFFF.
- R3: Base 0x60 with mask 0x1F claims 0x6000_0000 to 0x7FFF_FFFF, and claims neither 0x5FFF_FFFF nor 0x8000_0000.
- R4: Register bit 15 enables the region. A region whose bit 15 is clear never claims an address, and writing zero to a register removes its window.
- R5: Register bits 14:13 gate privilege: 1x admits both levels, 01 admits supervisor accesses only, and 00 admits user accesses only.
- R6: Register bits 9:8 gate the access type: 1x admits both, 01 admits instruction fetches only, and 00 admits data accesses only.
- R7: When several regions claim an access, the lowest-numbered one wins, and its number appears on `hit_idx`.
- R8: `cache_mode` carries bits 6:5 and `wprot` carries bit 2 of the winning region. Both are zero when no region hits.
- R9: `wr_fault` is high exactly when a write access hits a region whose write-protect bit is set.
- R10: Lookups are combinational. A register write changes lookup results only after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Register number to write |
| wr_data | input | 32 | Value to write |
| lk_addr | input | 32 | Lookup address |
| lk_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| lk_super | input | 1 | 1 = supervisor access, 0 = user access |
| lk_write | input | 1 | 1 = write access |
| hit | output | 1 | A region claims the access, so translation is bypassed |
| hit_idx | output | 2 | Number of the winning region |
| cache_mode | output | 2 | Cache mode of the winning region |
| wprot | output | 1 | Winning region is write-protected |
| wr_fault | output | 1 | Write to a write-protected region |

## Verification
Every lookup output is due in the same cycle as the address and access type that produce it. The bench therefore applies each lookup, waits one time step without any clock edge in between, and compares all five outputs at once. Register writes take effect one edge later. The bench drives a write at the falling edge, probes the old result before the rising edge, and probes the new result after it. Each configuration is then swept over all 256 top-byte values and all eight access-type, privilege and write combinations.

// File: rtl/acr_match.sv
module acr_match #(
  parameter int NREG = 4,
  parameter int AW   = 32,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] lk_addr,
  input  logic          lk_instr,
  input  logic          lk_super,
  input  logic          lk_write,
  output logic          hit,
  output logic [IW-1:0] hit_idx,
  output logic [1:0]    cache_mode,
  output logic          wprot,
  output logic          wr_fault
);
  logic [NREG-1:0][31:0] acr;
  logic [NREG-1:0]       sel;
  wire  [7:0]            top = lk_addr[AW-1:AW-8];

  always_ff @(posedge clk) begin
    if (!rst_n) acr <= '0;
    else if (wr_en && int'(wr_idx) < NREG) acr[wr_idx] <= wr_data;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    wire hit_addr = ((top ^ acr[g][31:24]) & ~acr[g][23:16]) == 8'h00;
    wire priv_ok  = acr[g][14] | (acr[g][13] ? lk_super : ~lk_super);
    wire type_ok  = acr[g][9]  | (acr[g][8]  ? lk_instr : ~lk_instr);
    assign sel[g] = acr[g][15] & hit_addr & priv_ok & type_ok;
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (sel[i]) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
  end

  assign cache_mode = hit ? acr[hit_idx][6:5] : 2'b00;
  assign wprot      = hit & acr[hit_idx][2];
  assign wr_fault   = wprot & lk_write;
endmodule

module acr_match_chk #(
  parameter int NREG = 4,
  parameter int IW   = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [IW-1:0]         wr_idx,
  input logic [31:0]           wr_data,
  input logic                  lk_write,
  input logic                  hit,
  input logic [IW-1:0]         hit_idx,
  input logic [1:0]            cache_mode,
  input logic                  wprot,
  input logic                  wr_fault,
  input logic [NREG-1:0][31:0] acr
);
  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (acr == '0));

  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> acr[$past(wr_idx)] == $past(wr_data));

  p_hit_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> acr[hit_idx][15]);

  p_nohit_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (cache_mode == 2'b00 && !wprot && !wr_fault));

  p_fault_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |-> (hit && lk_write && acr[hit_idx][2]));
endmodule

bind acr_match acr_match_chk #(.NREG(NREG), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .lk_write(lk_write), .hit(hit), .hit_idx(hit_idx), .cache_mode(cache_mode),
  .wprot(wprot), .wr_fault(wr_fault), .acr(acr)
);

// File: tb/sim_acr_match.sv
module sim_acr_match;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_idx = 0;
  logic [31:0] wr_data = 0, lk_addr = 0;
  logic lk_instr = 0, lk_super = 0, lk_write = 0;
  logic hit, wprot, wr_fault;
  logic [1:0] hit_idx, cache_mode;
  int errors = 0, checks = 0;
  logic [31:0] m [4];

  always #5 clk = ~clk;

  acr_match u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .lk_addr(lk_addr), .lk_instr(lk_instr),
    .lk_super(lk_super), .lk_write(lk_write), .hit(hit), .hit_idx(hit_idx),
    .cache_mode(cache_mode), .wprot(wprot), .wr_fault(wr_fault));

  // register value: base, mask, enable, priv(2b), type(2b), cache mode, wp
  function automatic logic [31:0] mk(input logic [7:0] b, input logic [7:0] k,
      input logic en, input logic [1:0] pv, input logic [1:0] ty,
      input logic [1:0] cm, input logic wp);
    return {b, k, en, pv, 3'b0, ty, 1'b0, cm, 2'b0, wp, 2'b0};
  endfunction

  function automatic logic [6:0] expect_of(input logic [31:0] a, input logic ins,
      input logic sup, input logic wrt);
    logic [6:0] r = 7'd0;
    for (int i = 3; i >= 0; i--) begin
      logic am, pm, tm;
      am = (((a[31:24] ^ m[i][31:24]) & ~m[i][23:16]) == 8'h00);
      pm = m[i][14] || (m[i][13] == sup);
      tm = m[i][9]  || (m[i][8] == ins);
      if (m[i][15] && am && pm && tm)
        r = {1'b1, 2'(i), m[i][6:5], m[i][2], m[i][2] & wrt};
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [6:0] exp_v);
    logic [6:0] act = {hit, hit_idx, cache_mode, wprot, wr_fault};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s addr=%h ins=%b sup=%b wr=%b actual=%b expected=%b",
               req, lk_addr, lk_instr, lk_super, lk_write, act, exp_v);
    end
  endtask

  task automatic look(input logic [31:0] a, input logic ins, input logic sup, input logic wrt);
    lk_addr = a; lk_instr = ins; lk_super = sup; lk_write = wrt; #1;
  endtask

  task automatic wr(input int i, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_idx = 2'(i); wr_data = d;
    @(posedge clk); #1; wr_en = 0; m[i] = d;
  endtask

  task automatic sweep(input string req);
    for (int b = 0; b < 256; b++)
      for (int c = 0; c < 8; c++) begin
        logic [31:0] a = {8'(b), 8'(b) ^ 8'hA5, 16'(b * 37)};
        look(a, c[0], c[1], c[2]);
        chk(req, expect_of(a, c[0], c[1], c[2]));
      end
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: nothing hits after reset
    look(32'hC000_0000, 0, 1, 1); chk("R1", 7'd0);
    look(32'h0000_0000, 1, 0, 0); chk("R1", 7'd0);

    // R2 boundaries, single region, all access kinds
    wr(0, mk(8'hC0, 8'h3F, 1, 2'b10, 2'b10, 2'b10, 0));
    look(32'hC000_0000, 0, 0, 0); chk("R2", {1'b1, 2'd0, 2'b10, 1'b0, 1'b0});
    look(32'hFFFF_FFFF, 1, 1, 1); chk("R2", {1'b1, 2'd0, 2'b10, 1'b0, 1'b0});
    look(32'hBFFF_FFFF, 0, 0, 0); chk("R2", 7'd0);

    // R10: a write is not visible before its capturing edge
    @(negedge clk); wr_en = 1; wr_idx = 1; wr_data = mk(8'h60, 8'h1F, 1, 2'b10, 2'b10, 2'b00, 1);
    look(32'h6000_0000, 0, 0, 1); chk("R10", 7'd0);
    @(posedge clk); #1; wr_en = 0; m[1] = wr_data;
    look(32'h6000_0000, 0, 0, 1); chk("R10", {1'b1, 2'd1, 2'b00, 1'b1, 1'b1});
    // R3 boundaries and R9 read vs write
    look(32'h7FFF_FFFF, 0, 0, 0); chk("R3 R9", {1'b1, 2'd1, 2'b00, 1'b1, 1'b0});
    look(32'h5FFF_FFFF, 0, 0, 1); chk("R3", 7'd0);
    look(32'h8000_0000, 0, 0, 1); chk("R3", 7'd0);

    // R5 and R6: supervisor-only, instruction-only window
    wr(2, mk(8'h20, 8'h00, 1, 2'b01, 2'b01, 2'b01, 0));
    look(32'h2000_1000, 1, 1, 0); chk("R5 R6", {1'b1, 2'd2, 2'b01, 1'b0, 1'b0});
    look(32'h2000_1000, 1, 0, 0); chk("R5", 7'd0);
    look(32'h2000_1000, 0, 1, 0); chk("R6", 7'd0);
    // catch-all user data region, lowest priority
    wr(3, mk(8'h00, 8'hFF, 1, 2'b00, 2'b00, 2'b11, 1));
    look(32'h2000_1000, 0, 0, 1); chk("R5 R6 R9", {1'b1, 2'd3, 2'b11, 1'b1, 1'b1});
    // R7: region 0 beats region 3 on overlap
    look(32'hE000_0000, 0, 0, 1); chk("R7", {1'b1, 2'd0, 2'b10, 1'b0, 1'b0});
    sweep("R2 R5 R6 R7 R8 R9");

    // R4: enable bit clear, then zero write
    wr(0, mk(8'hC0, 8'h3F, 0, 2'b10, 2'b10, 2'b10, 0));
    look(32'hC000_0000, 0, 1, 0); chk("R4", 7'd0);
    wr(3, 32'h0);
    look(32'h1234_5678, 0, 0, 1); chk("R4", 7'd0);
    sweep("R4 R7 R8");

    // second overlapping configuration
    wr(0, mk(8'h40, 8'hBF, 1, 2'b00, 2'b10, 2'b01, 1));
    wr(3, mk(8'h80, 8'h7F, 1, 2'b11, 2'b00, 2'b10, 0));
    sweep("R2 R5 R6 R7 R8 R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule